// File: doc/BRIEF.md
# Digital Volume Ramp with Quiet-Signal Automute

This block produces the effective gain code for one audio channel in quarter-decibel steps. A programmed volume sets the target gain. The applied gain either jumps to that target or slides toward it one quarter decibel at a time. The slide rate is counted in sample-strobe periods, and each rate code doubles the count of the one before it. The block does not convert the code to a linear multiplier, and it does not scale the samples.

A quiet-signal detector sits next to the ramp. It estimates the level of each sample magnitude in the log domain, from the leading-one position plus the next bit below it, which gives about 3 dB of resolution. It compares that level against a noise-gate threshold whose encoding is piecewise. When a whole window of consecutive samples stays under the threshold, the detector asserts. The target is then lowered by a programmed depth, and the applied gain moves to the new target at the same ramp rate as any volume change.

Top module: `vol_ramp_automute`

## Requirements
- R1: While reset is asserted and after its release, before any other stimulus, `gain_o` is 0 and `am_active_o` is 0.
- R2: The unmuted target gain code is 2×`vol_i`. The volume code means -95.5 dB + 0.5 dB×code, and the gain code means -95.5 dB + 0.25 dB×code.
- R3: With `ramp_rate_i` = 0, `gain_o` equals the target on the clock edge after the target changes, whether or not any strobe arrives.
- R4: With `ramp_rate_i` = r in 1..15, `gain_o` moves by exactly one code toward the target on every 2^(r+1)-th strobe. The strobes are counted from the last time the gain equalled the target, and the gain holds once it reaches the target.
- R5: With a nonzero rate and `smp_stb_i` low, `gain_o` does not change.
- R6: Sample level: let p be the position of the highest set bit of `smp_mag_i` and b the bit just below it. The level is 2p+b+2 for a nonzero magnitude and 0 for zero. A sample is quiet when its level is below the gate level. For `am_gate_i` = g, the gate level is 2g+1 when g < 8 and g+8 when g ≥ 8. One level unit is 3 dB, and level 33 is full scale.
- R7: With window code n, `am_active_o` rises on the edge of the 2048×(n+1)-th consecutive quiet strobe, and not one strobe earlier.
- R8: A strobed sample that is not quiet clears `am_active_o` on that edge and restarts the window count.
- R9: With `am_en_i` low, `am_active_o` is 0 from the next edge on, and it never asserts however many quiet samples arrive.
- R10: While muted, the target is max(0, 2×`vol_i` - 112 + 16×`am_depth_i`). The depth code d means a change of -28 dB + 4 dB×d, so d = 7 leaves the target unchanged.
- R11: Entering and leaving automute ramps the gain at the programmed rate, exactly as a volume change would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One pulse per sample period |
| smp_mag_i | input | 16 | Sample magnitude, valid with the strobe |
| vol_i | input | 8 | Volume code, 0.5 dB per step |
| ramp_rate_i | input | 4 | 0 = jump, else one step per 2^(r+1) strobes |
| am_en_i | input | 1 | Automute detector enable |
| am_win_i | input | 4 | Window length code, 2048×(n+1) samples |
| am_gate_i | input | 4 | Noise-gate threshold code |
| am_depth_i | input | 3 | Automute depth code, 4 dB per step |
| gain_o | output | 9 | Applied gain code, 0.25 dB per step |
| am_active_o | output | 1 | Automute detector asserted |

## Verification
The table of vectors puts magnitudes one estimator bit either side of several gate codes, including the gate code at the boundary between the two threshold encodings. A misread threshold segment or a dropped half-bit would therefore flip mute on or off and give the wrong gain. The directed tests count the window to its last strobe, so an off-by-one window asserts either one sample early or one sample late. They also put a loud sample in the middle of a window, so a count that is not cleared mutes too soon. Ramp checks sample the gain on the strobe before each step and on the step itself, at rates 1, 3 and 15. They also hold the strobe low. A period with a shift that is one off, or a counter that counts clocks instead of strobes, moves the steps or causes steps without strobes. The mute-entry and mute-exit checks catch a design that jumps the gain instead of ramping it, and one whose muted target underflows or is not clamped.

// File: rtl/vr_pkg.sv
package vr_pkg;
    // quarter-dB codes per volume step
    localparam int unsigned QDB_PER_VOL = 2;
    // muted offset: -28 dB base, +4 dB per depth step, in quarter dB
    localparam int unsigned DEPTH_BASE_Q = 112;
    localparam int unsigned DEPTH_STEP_Q = 16;
    // magnitude width at which the level scale is referenced
    localparam int unsigned REF_MAG_W = 16;

    // gate code -> level in 3 dB units (fine segment above code 7)
    function automatic int unsigned gate_level(input logic [3:0] code);
        if (code[3]) return 32'(code) + 32'd8;
        return 32'd2 * 32'(code) + 32'd1;
    endfunction
endpackage

// File: rtl/vr_level_est.sv
module vr_level_est #(
    parameter int unsigned MAG_W = 16
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic [3:0]       gate_i,
    output logic             quiet_o
);
    localparam int SHIFT = 2 * (int'(MAG_W) - int'(vr_pkg::REF_MAG_W)) - 2;

    always_comb begin
        int   pos_d;
        logic nb_d;
        int   lvl_d;
        pos_d = 0;
        nb_d  = 1'b0;
        for (int i = 1; i < int'(MAG_W); i++) begin
            if (mag_i[i]) begin
                pos_d = i;
                nb_d  = mag_i[i-1];
            end
        end
        lvl_d = 2 * pos_d + int'(nb_d) - SHIFT;
        if (mag_i == '0 || lvl_d < 0) lvl_d = 0;
        quiet_o = (lvl_d < int'(vr_pkg::gate_level(gate_i)));
    end
endmodule

// File: rtl/vr_quiet_win.sv
module vr_quiet_win #(
    parameter int unsigned WIN_UNIT = 2048,
    parameter int unsigned WCODE_W  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               stb_i,
    input  logic               en_i,
    input  logic [WCODE_W-1:0] win_i,
    input  logic               quiet_i,
    output logic               active_o
);
    localparam int unsigned WIN_MAX = WIN_UNIT * (2 ** WCODE_W);
    localparam int unsigned CNT_W   = $clog2(WIN_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        last_d = CNT_W'((32'(win_i) + 32'd1) * WIN_UNIT - 32'd1);
        if (!en_i) begin
            st_d.cnt    = '0;
            st_d.active = 1'b0;
        end else if (stb_i) begin
            if (!quiet_i) begin
                st_d.cnt    = '0;
                st_d.active = 1'b0;
            end else if (st_q.cnt == last_d) begin
                st_d.active = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;

    assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !active_o);
    assert_loud_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && stb_i && !quiet_i) |=> !active_o);
    assert_onset_on_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o) |-> $past(stb_i && quiet_i && en_i));
endmodule

// File: rtl/vr_ramp.sv
module vr_ramp #(
    parameter int unsigned GAIN_W = 9,
    parameter int unsigned RATE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [GAIN_W-1:0] target_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int unsigned CNT_W = 2 ** RATE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [GAIN_W-1:0] gain;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic [CNT_W-1:0] lim_d;

    always_comb begin
        st_d  = st_q;
        lim_d = CNT_W'((64'd1 << (32'(rate_i) + 32'd1)) - 64'd1);
        if (rate_i == '0) begin
            st_d.gain = target_i;
            st_d.cnt  = '0;
        end else if (st_q.gain == target_i) begin
            st_d.cnt = '0;
        end else if (stb_i) begin
            if (st_q.cnt == lim_d) begin
                st_d.cnt  = '0;
                st_d.gain = (st_q.gain < target_i) ? st_q.gain + 1'b1
                                                   : st_q.gain - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gain_o = st_q.gain;

    assert_jump_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_i == '0) |=> (gain_o == $past(target_i)));
    assert_unit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_i != '0) |=> (gain_o == $past(gain_o) || gain_o == $past(gain_o) + 1'b1
                            || gain_o + 1'b1 == $past(gain_o)));
    assert_hold_no_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_i != '0 && !stb_i) |=> $stable(gain_o));
endmodule

// File: rtl/vol_ramp_automute.sv
module vol_ramp_automute #(
    parameter int unsigned MAG_W    = 16,
    parameter int unsigned VOL_W    = 8,
    parameter int unsigned RATE_W   = 4,
    parameter int unsigned WCODE_W  = 4,
    parameter int unsigned DEPTH_W  = 3,
    parameter int unsigned WIN_UNIT = 2048,
    localparam int unsigned GAIN_W  = VOL_W + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               smp_stb_i,
    input  logic [MAG_W-1:0]   smp_mag_i,
    input  logic [VOL_W-1:0]   vol_i,
    input  logic [RATE_W-1:0]  ramp_rate_i,
    input  logic               am_en_i,
    input  logic [WCODE_W-1:0] am_win_i,
    input  logic [3:0]         am_gate_i,
    input  logic [DEPTH_W-1:0] am_depth_i,
    output logic [GAIN_W-1:0]  gain_o,
    output logic               am_active_o
);
    logic              quiet;
    logic [GAIN_W-1:0] target_d;

    vr_level_est #(.MAG_W(MAG_W)) level_i (
        .mag_i   (smp_mag_i),
        .gate_i  (am_gate_i),
        .quiet_o (quiet)
    );

    vr_quiet_win #(.WIN_UNIT(WIN_UNIT), .WCODE_W(WCODE_W)) win_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (smp_stb_i),
        .en_i     (am_en_i),
        .win_i    (am_win_i),
        .quiet_i  (quiet),
        .active_o (am_active_o)
    );

    always_comb begin
        int t_d;
        t_d = int'(vr_pkg::QDB_PER_VOL) * int'(vol_i);
        if (am_active_o) begin
            t_d = t_d - int'(vr_pkg::DEPTH_BASE_Q)
                      + int'(vr_pkg::DEPTH_STEP_Q) * int'(am_depth_i);
            if (t_d < 0) t_d = 0;
        end
        target_d = GAIN_W'(t_d);
    end

    vr_ramp #(.GAIN_W(GAIN_W), .RATE_W(RATE_W)) ramp_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (smp_stb_i),
        .rate_i   (ramp_rate_i),
        .target_i (target_d),
        .gain_o   (gain_o)
    );

    assert_zero_is_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_mag_i == '0) |-> quiet);
    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (gain_o == '0 && !am_active_o));
endmodule

// File: tb/vol_ramp_automute_tb_top.sv
`timescale 1ns/1ps
module vol_ramp_automute_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        stb = 1'b0;
    logic [15:0] mag = '0;
    logic [7:0]  vol = '0;
    logic [3:0]  rate = '0;
    logic        en = 1'b0;
    logic [3:0]  win = '0;
    logic [3:0]  gate = '0;
    logic [2:0]  depth = '0;
    logic [8:0]  gain;
    logic        act;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vol_ramp_automute dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .smp_stb_i(stb), .smp_mag_i(mag),
        .vol_i(vol), .ramp_rate_i(rate), .am_en_i(en), .am_win_i(win),
        .am_gate_i(gate), .am_depth_i(depth), .gain_o(gain), .am_active_o(act)
    );

    typedef struct packed {
        logic [7:0]  vol;
        logic [2:0]  depth;
        logic [3:0]  gate;
        logic [15:0] mag;
        logic        act;
        logic [8:0]  gain;
    } vec_t;

    // R2/R6/R10 table: magnitudes one estimator step either side of the gate
    localparam vec_t VECS [8] = '{
        '{8'd200, 3'd0, 4'd15, 16'h05FF, 1'b1, 9'd288},
        '{8'd200, 3'd3, 4'd15, 16'h0600, 1'b0, 9'd400},
        '{8'd20,  3'd0, 4'd7,  16'h0020, 1'b1, 9'd0},
        '{8'd255, 3'd7, 4'd7,  16'h0040, 1'b1, 9'd510},
        '{8'd100, 3'd5, 4'd0,  16'h0000, 1'b1, 9'd168},
        '{8'd100, 3'd5, 4'd0,  16'h0001, 1'b0, 9'd200},
        '{8'd150, 3'd2, 4'd8,  16'h0080, 1'b0, 9'd300},
        '{8'd150, 3'd2, 4'd9,  16'h0080, 1'b1, 9'd220}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic strobe_n(input int n, input logic [15:0] m);
        for (int k = 0; k < n; k++) begin
            stb = 1'b1;
            mag = m;
            @(posedge clk);
            #1;
        end
        stb = 1'b0;
    endtask

    task automatic idle(input int n);
        stb = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    localparam logic [15:0] LOUD = 16'hFFFF;
    localparam logic [15:0] SOFT = 16'h0100; // level 18, quiet under gate 15

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 gain in reset", int'(gain), 0);
        check("R1 mute in reset", int'(act), 0);
        rst_ni = 1'b1;
        idle(1);
        check("R1 gain after reset", int'(gain), 0);

        // vector walk
        for (int v = 0; v < 8; v++) begin
            rate = 4'd0; en = 1'b1; win = 4'd0;
            vol = VECS[v].vol; depth = VECS[v].depth; gate = VECS[v].gate;
            strobe_n(1, LOUD);
            strobe_n(2048, VECS[v].mag);
            idle(2);
            check($sformatf("R6 vec%0d mute", v), int'(act), int'(VECS[v].act));
            check($sformatf("R2/R10 vec%0d gain", v), int'(gain), int'(VECS[v].gain));
        end

        // R7 window edge, code 0
        vol = 8'd200; depth = 3'd0; gate = 4'd15; win = 4'd0; en = 1'b1;
        strobe_n(1, LOUD);
        strobe_n(2047, SOFT);
        check("R7 2047 quiet", int'(act), 0);
        strobe_n(1, SOFT);
        check("R7 2048 quiet", int'(act), 1);
        idle(1);
        check("R10 muted gain", int'(gain), 288);

        // R8 loud sample clears and restarts
        strobe_n(1, LOUD);
        check("R8 loud clears", int'(act), 0);
        idle(1);
        check("R3 unmute jump", int'(gain), 400);
        strobe_n(2000, SOFT);
        strobe_n(1, LOUD);
        strobe_n(2047, SOFT);
        check("R8 count restarted", int'(act), 0);
        strobe_n(1, SOFT);
        check("R8 full window after restart", int'(act), 1);

        // R7 window code 1
        win = 4'd1;
        strobe_n(1, LOUD);
        strobe_n(4095, SOFT);
        check("R7 code1 4095", int'(act), 0);
        strobe_n(1, SOFT);
        check("R7 code1 4096", int'(act), 1);

        // R9 enable low
        en = 1'b0;
        idle(1);
        check("R9 disable clears", int'(act), 0);
        strobe_n(4100, SOFT);
        check("R9 never asserts", int'(act), 0);
        idle(1);
        check("R9 gain unmuted", int'(gain), 400);

        // R4 ramp rate 1 (4 strobes per step)
        vol = 8'd100;
        idle(2);
        check("R3 jump to 200", int'(gain), 200);
        rate = 4'd1; vol = 8'd101;
        strobe_n(3, LOUD);
        check("R4 rate1 before step", int'(gain), 200);
        strobe_n(1, LOUD);
        check("R4 rate1 first step", int'(gain), 201);
        strobe_n(4, LOUD);
        check("R4 rate1 second step", int'(gain), 202);
        strobe_n(8, LOUD);
        check("R4 holds at target", int'(gain), 202);
        vol = 8'd100;
        strobe_n(3, LOUD);
        check("R4 down before step", int'(gain), 202);
        strobe_n(1, LOUD);
        check("R4 down step", int'(gain), 201);
        idle(50);
        check("R5 no strobe no step", int'(gain), 201);
        strobe_n(4, LOUD);
        check("R4 down to target", int'(gain), 200);

        // R4 rate 3 (16 strobes per step)
        rate = 4'd3; vol = 8'd102;
        strobe_n(15, LOUD);
        check("R4 rate3 before step", int'(gain), 200);
        strobe_n(1, LOUD);
        check("R4 rate3 step", int'(gain), 201);
        strobe_n(16, LOUD);
        check("R4 rate3 second step", int'(gain), 202);

        // R4 rate 15 (65536 strobes per step)
        rate = 4'd15; vol = 8'd103;
        strobe_n(65535, LOUD);
        check("R4 rate15 before step", int'(gain), 202);
        strobe_n(1, LOUD);
        check("R4 rate15 step", int'(gain), 203);
        rate = 4'd0;
        idle(1);
        check("R3 jump after rate 0", int'(gain), 206);

        // R11 mute entry and exit ramp at rate 1
        rate = 4'd1; en = 1'b1; win = 4'd0; gate = 4'd15; depth = 3'd0;
        strobe_n(1, LOUD);
        strobe_n(2048, SOFT);
        check("R11 mute asserted", int'(act), 1);
        check("R11 no jump on entry", int'(gain), 206);
        strobe_n(8, SOFT);
        check("R11 entry ramp", int'(gain), 204);
        strobe_n(1, LOUD);
        check("R11 mute released", int'(act), 0);
        strobe_n(2, LOUD);
        check("R11 exit before step", int'(gain), 204);
        strobe_n(1, LOUD);
        check("R11 exit step", int'(gain), 205);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule